// File: doc/BRIEF.md
# Watchdog Timer With Interrupt Mode

This block is a watchdog with a single 8-bit control and status byte. A free-running counter advances on every clock and restarts whenever software pulses the kick input. If the count reaches the period picked by a 4-bit prescaler code, the block reaches a timeout. The enable bits in the control byte decide what happens next. A timeout can set an interrupt flag. It can request a one-cycle system reset. In the combined mode it first interrupts and then resets on the following timeout. It can also do nothing at all.

The reset-enable bit and the prescaler code are protected. A write changes them only while a short unlock window is open, and software opens that window by writing the change-enable bit. The interrupt request output is the timeout flag gated by the interrupt-enable bit and a global interrupt enable. The interrupt vector logic clears the flag with an acknowledge pulse, and software can also clear it by writing a one.

Top module: `wdog_timer`

## Requirements
- R1: Synchronous reset loads every control bit with zero, except the reset-enable bit, which takes the value of `rst_en_init`. The read byte is laid out as: bit 7 timeout flag, bit 6 interrupt enable, bit 5 prescaler bit 3, bit 4 unlock-window status, bit 3 reset enable, bits 2:0 prescaler bits 2:0. Out of reset the outputs `irq` and `rst_req` are low.
- R2: A timeout occurs 2^(BASE_EXP+P) clocks after the counter was last cleared, where P is the prescaler code. Codes above PSC_MAX act as PSC_MAX but read back exactly as written. A timeout restarts the count.
- R3: The counter is cleared in every cycle in which `kick` is high. A kick in the cycle that would have timed out suppresses that timeout.
- R4: Writing bit 4 as one opens a window of UNLOCK_WIN cycles, and bit 4 reads one while the window is open. Only writes that land inside that window, after the opening write, update the reset-enable bit and the prescaler code. The interrupt-enable bit and the flag clear are not protected.
- R5: In interrupt mode (interrupt enable 1, reset enable 0), a timeout sets the flag and does not assert `rst_req`.
- R6: In reset mode (reset enable 1, interrupt enable 0), a timeout asserts `rst_req` for exactly one cycle and leaves the flag clear.
- R7: With both enables set, a timeout sets the flag and clears the interrupt-enable bit in hardware, so the next timeout asserts `rst_req`.
- R8: With both enables clear, a timeout neither sets the flag nor asserts `rst_req`.
- R9: The flag clears on `irq_ack` or on a write with bit 7 equal to one. Writing bit 7 as zero leaves the flag unchanged. A timeout that sets the flag wins over a clear in the same cycle.
- R10: `irq` is registered. In each cycle it equals flag AND interrupt enable (the values visible in that same cycle) AND the `gie` value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_en_init | input | 1 | Value loaded into the reset-enable bit at reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control byte read data |
| kick | input | 1 | Clears the timeout counter |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt vector taken; clears the flag |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench looks for an off-by-one in the timeout period at several prescaler codes, including one above the limit. A design that got this wrong would raise the flag one cycle early or late, or would lock up at an oversize code. It probes both edges of the unlock window: a design that counted the window wrongly would accept a late write or reject one in the last open cycle. It also checks a clear that coincides with a timeout, a flag write of zero, and the automatic drop of interrupt enable in the combined mode. A design that got these wrong would lose an interrupt, clear the flag when it should not, or never reach the reset. Randomised sequences of `gie`, acknowledge and write traffic then check the interrupt gating and its one-cycle delay against a model in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CSR_W = 8;
  localparam int PSC_W = 4;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic             psc_hi;
    logic             unlock;
    logic             re;
    logic [2:0]       psc_lo;
  } wdog_csr_t;

  function automatic logic [PSC_W-1:0] csr_psc(input logic [CSR_W-1:0] b);
    return {b[5], b[2:0]};
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_EXP = 11,
  parameter int PSC_MAX  = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      kick,
  input  logic [wdog_pkg::PSC_W-1:0] psc,
  output logic                      tmo
);
  localparam int CW    = BASE_EXP + PSC_MAX;
  localparam int CODES = 1 << wdog_pkg::PSC_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term_tab [CODES];
  logic          hit;

  for (genvar g = 0; g < CODES; g++) begin : g_term
    localparam int SH = BASE_EXP + ((g > PSC_MAX) ? PSC_MAX : g);
    if (SH >= CW) begin : g_full
      assign term_tab[g] = '1;
    end else begin : g_part
      assign term_tab[g] = CW'((64'd1 << SH) - 64'd1);
    end
  end

  assign hit = (cnt_q >= term_tab[psc]);
  assign tmo = hit && !kick;

  always_ff @(posedge clk) begin
    if (rst || kick || hit) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  p_kick_clears_r3: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr #(
  parameter int UNLOCK_WIN = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rst_en_init,
  input  logic                        wr_en,
  input  logic [wdog_pkg::CSR_W-1:0]  wr_data,
  input  logic                        tmo,
  input  logic                        irq_ack,
  output logic                        flag_q,
  output logic                        ie_q,
  output logic                        re_q,
  output logic                        flag_nxt,
  output logic                        ie_nxt,
  output logic [wdog_pkg::PSC_W-1:0]  psc_q,
  output logic [wdog_pkg::CSR_W-1:0]  csr_byte
);
  import wdog_pkg::*;
  localparam int WW = $clog2(UNLOCK_WIN + 1);
  localparam logic [WW-1:0] WIN_LOAD = WW'(UNLOCK_WIN);

  logic [WW-1:0] win_q;
  logic          win_open;
  logic          clr_req;
  wdog_csr_t     view;

  assign win_open = (win_q != '0);
  assign clr_req  = (wr_en && wr_data[7]) || irq_ack;

  always_comb begin
    ie_nxt = wr_en ? wr_data[6] : ie_q;
    if (tmo && ie_q && re_q) ie_nxt = 1'b0;
    flag_nxt = flag_q;
    if (clr_req)       flag_nxt = 1'b0;
    if (tmo && ie_q)   flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      re_q   <= rst_en_init;
      psc_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en && wr_data[4]) win_q <= WIN_LOAD;
      else if (win_open)       win_q <= win_q - WW'(1);
      if (wr_en && win_open) begin
        re_q  <= wr_data[3];
        psc_q <= csr_psc(wr_data);
      end
      ie_q   <= ie_nxt;
      flag_q <= flag_nxt;
    end
  end

  always_comb begin
    view.flag   = flag_q;
    view.ie     = ie_q;
    view.psc_hi = psc_q[3];
    view.unlock = win_open;
    view.re     = re_q;
    view.psc_lo = psc_q[2:0];
    csr_byte    = view;
  end

  p_locked_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !win_open) |=> ($stable(re_q) && $stable(psc_q)));
  p_window_opens_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[4]) |=> (csr_byte[4] == 1'b1));
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !irq_ack && !(wr_en && wr_data[7])) |=> flag_q);
endmodule

// File: rtl/wdog_irq_gate.sv
module wdog_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic flag_nxt,
  input  logic ie_nxt,
  input  logic gie,
  input  logic tmo,
  input  logic ie_q,
  input  logic re_q,
  output logic irq,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= flag_nxt && ie_nxt && gie;
      rst_req <= tmo && re_q && !ie_q;
    end
  end

  p_rst_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  p_irq_needs_gie_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_EXP   = 11,
  parameter int PSC_MAX    = 9,
  parameter int UNLOCK_WIN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_en_init,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       kick,
  input  logic       gie,
  input  logic       irq_ack,
  output logic       irq,
  output logic       rst_req
);
  import wdog_pkg::*;

  logic             tmo;
  logic             flag_q, ie_q, re_q, flag_nxt, ie_nxt;
  logic [PSC_W-1:0] psc_q;

  wdog_counter #(.BASE_EXP(BASE_EXP), .PSC_MAX(PSC_MAX)) u_cnt (
    .clk(clk), .rst(rst), .kick(kick), .psc(psc_q), .tmo(tmo)
  );

  wdog_csr #(.UNLOCK_WIN(UNLOCK_WIN)) u_csr (
    .clk(clk), .rst(rst), .rst_en_init(rst_en_init),
    .wr_en(wr_en), .wr_data(wr_data), .tmo(tmo), .irq_ack(irq_ack),
    .flag_q(flag_q), .ie_q(ie_q), .re_q(re_q),
    .flag_nxt(flag_nxt), .ie_nxt(ie_nxt), .psc_q(psc_q), .csr_byte(rd_data)
  );

  wdog_irq_gate u_gate (
    .clk(clk), .rst(rst), .flag_nxt(flag_nxt), .ie_nxt(ie_nxt), .gie(gie),
    .tmo(tmo), .ie_q(ie_q), .re_q(re_q), .irq(irq), .rst_req(rst_req)
  );

  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q && ie_q));
  p_irq_mode_no_reset_r5: assert property (@(posedge clk) disable iff (rst)
    (tmo && ie_q && !re_q) |=> (!rst_req && flag_q));
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int BE = 4;
  localparam int PM = 9;

  logic       clk = 1'b0;
  logic       rst, rst_en_init, wr_en, kick, gie, irq_ack;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq, rst_req;
  int         checks = 0;
  int         fails  = 0;

  always #2 clk = ~clk;

  wdog_timer #(.BASE_EXP(BE), .PSC_MAX(PM), .UNLOCK_WIN(4)) uut (
    .clk(clk), .rst(rst), .rst_en_init(rst_en_init), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .kick(kick), .gie(gie),
    .irq_ack(irq_ack), .irq(irq), .rst_req(rst_req)
  );

  function automatic logic [7:0] mk(input logic f, input logic ie,
      input logic ce, input logic re, input logic [3:0] p);
    return {f, ie, p[3], ce, re, p[2:0]};
  endfunction

  function automatic int lim(input int p);
    return 1 << (BE + ((p > PM) ? PM : p));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic cfg(input logic ie, input logic re, input logic [3:0] p);
    kick = 1'b1;
    wr(mk(1'b1, 1'b0, 1'b1, 1'b0, 4'd0));
    wr(mk(1'b1, ie, 1'b0, re, p));
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int L;
    int pulses, flags;
    logic flag_m, ie_m, g, a, w;
    logic [7:0] d;
    void'($urandom(32'd2024));
    rst = 1'b1; rst_en_init = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    kick = 1'b1; gie = 1'b0; irq_ack = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R1 csr after reset", rd_data, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 rst_req after reset", rst_req, 0);
    rst = 1'b1; rst_en_init = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(1);
    chk("R1 reset enable from init", rd_data, 8'h08);
    rst_en_init = 1'b0;

    // R5 / R2 code 0
    cfg(1'b1, 1'b0, 4'd0); L = lim(0);
    kick = 1'b0;
    wait_n(L - 1); chk("R2 no flag before period p0", rd_data[7], 0);
    wait_n(1);     chk("R5 flag at period p0", rd_data[7], 1);
    chk("R5 no reset in irq mode", rst_req, 0);
    kick = 1'b1;

    // R2 code 2
    cfg(1'b1, 1'b0, 4'd2); L = lim(2);
    kick = 1'b0;
    wait_n(L - 1); chk("R2 no flag before period p2", rd_data[7], 0);
    wait_n(1);     chk("R2 flag at period p2", rd_data[7], 1);
    kick = 1'b1;

    // R2 oversize code
    cfg(1'b1, 1'b0, 4'd12); L = lim(12);
    chk("R2 oversize code reads back", {rd_data[5], rd_data[2:0]}, 12);
    kick = 1'b0;
    wait_n(L - 1); chk("R2 no flag before clamped period", rd_data[7], 0);
    wait_n(1);     chk("R2 flag at clamped period", rd_data[7], 1);
    kick = 1'b1;

    // R6 reset mode
    cfg(1'b0, 1'b1, 4'd0); L = lim(0);
    kick = 1'b0;
    wait_n(L - 1); chk("R6 no reset before period", rst_req, 0);
    wait_n(1);     chk("R6 reset pulse", rst_req, 1);
    chk("R6 flag stays clear", rd_data[7], 0);
    wait_n(1);     chk("R6 pulse one cycle", rst_req, 0);
    kick = 1'b1;

    // R3 kick at terminal cycle
    wait_n(1);
    kick = 1'b0;
    wait_n(L - 1);
    kick = 1'b1; wait_n(1); kick = 1'b0;
    chk("R3 kick suppresses timeout", rst_req, 0);
    wait_n(L - 1); chk("R3 counter restarted at kick", rst_req, 0);
    wait_n(1);     chk("R3 timeout after kick period", rst_req, 1);
    kick = 1'b1;

    // R7 combined mode
    cfg(1'b1, 1'b1, 4'd0);
    kick = 1'b0;
    wait_n(L);
    chk("R7 flag on first timeout", rd_data[7], 1);
    chk("R7 ie cleared by hardware", rd_data[6], 0);
    chk("R7 no reset on first timeout", rst_req, 0);
    wait_n(L - 1); chk("R7 no reset early", rst_req, 0);
    wait_n(1);     chk("R7 reset on second timeout", rst_req, 1);
    kick = 1'b1;

    // R8 neither
    cfg(1'b0, 1'b0, 4'd0);
    kick = 1'b0; pulses = 0; flags = 0;
    for (int i = 0; i < 3 * L; i++) begin
      wait_n(1);
      if (rst_req) pulses++;
      if (rd_data[7]) flags++;
    end
    chk("R8 no reset when disabled", pulses, 0);
    chk("R8 no flag when disabled", flags, 0);
    kick = 1'b1;

    // R4 unlock window
    wait_n(6);
    wr(mk(1'b0, 1'b0, 1'b0, 1'b1, 4'd3));
    chk("R4 locked write ignored", rd_data & 8'h2F, 0);
    wr(mk(1'b0, 1'b0, 1'b1, 1'b0, 4'd0));
    chk("R4 window status set", rd_data[4], 1);
    wait_n(3);
    wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 4'd5));
    chk("R4 write in last window cycle", rd_data[2:0], 5);
    wr(mk(1'b0, 1'b0, 1'b1, 1'b0, 4'd5));
    wait_n(4);
    chk("R4 window status cleared", rd_data[4], 0);
    wr(mk(1'b0, 1'b0, 1'b0, 1'b0, 4'd1));
    chk("R4 late write ignored", rd_data[2:0], 5);
    wr(mk(1'b0, 1'b1, 1'b0, 1'b0, 4'd0));
    chk("R4 ie unprotected", rd_data[6], 1);
    chk("R4 psc kept on ie write", rd_data[2:0], 5);

    // R9 flag clear rules
    cfg(1'b1, 1'b0, 4'd0);
    kick = 1'b0; wait_n(L); kick = 1'b1;
    chk("R9 flag set", rd_data[7], 1);
    wr(mk(1'b0, 1'b1, 1'b0, 1'b0, 4'd0));
    chk("R9 write zero keeps flag", rd_data[7], 1);
    irq_ack = 1'b1; wait_n(1); irq_ack = 1'b0;
    chk("R9 ack clears flag", rd_data[7], 0);
    kick = 1'b0; wait_n(L); kick = 1'b1;
    wr(mk(1'b1, 1'b1, 1'b0, 1'b0, 4'd0));
    chk("R9 write one clears flag", rd_data[7], 0);
    wait_n(1);
    kick = 1'b0; wait_n(L - 1);
    wr(mk(1'b1, 1'b1, 1'b0, 1'b0, 4'd0));
    chk("R9 timeout wins over clear", rd_data[7], 1);
    kick = 1'b1;

    // R10 gating
    gie = 1'b0; wait_n(1); chk("R10 irq off without gie", irq, 0);
    gie = 1'b1; wait_n(1); chk("R10 irq on with gie", irq, 1);
    gie = 1'b0; wait_n(1); chk("R10 irq drops with gie", irq, 0);
    flag_m = 1'b1; ie_m = 1'b1;
    for (int i = 0; i < 80; i++) begin
      g = 1'($urandom % 2);
      a = ($urandom % 10) == 0;
      w = ($urandom % 3) == 0;
      d = 8'h00;
      d[7] = ($urandom % 8) == 0;
      d[6] = ($urandom % 4) != 0;
      gie = g; irq_ack = a; wr_en = w; wr_data = d;
      if (w) ie_m = d[6];
      if ((w && d[7]) || a) flag_m = 1'b0;
      wait_n(1);
      chk("R10 random irq", irq, int'(flag_m && ie_m && g));
      chk("R9 random flag", rd_data[7], int'(flag_m));
    end
    wr_en = 1'b0; irq_ack = 1'b0; gie = 1'b0;
    wait_n(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule